// File: doc/BRIEF.md
# Inline Data To Memory Upload Engine

This block takes a stream of method writes and turns inline data words into a run of consecutive 32-bit memory writes. Each method write carries a register index and a 32-bit value. The value is stored in a small register file. Two indices also have side effects.

A write to the execute register rewinds an internal word counter to zero. Each write to the data register issues one memory write. Its address is a programmed 64-bit destination base plus four times the counter, and the counter then advances by one. Only linear uploads whose x, y and z origin fields are all zero are carried out. A data word that arrives under any other setting is dropped and raises a sticky error. The same error is raised by an index beyond the register file.

Memory writes leave on a valid/ready port. The method input is throttled so that no data word is lost while that port is stalled.

Top module: `inline_upload_engine`

## Requirements
- R1: After a synchronous active-high reset, `wr_valid` is 0, `err_flag` is 0, `meth_ready` is 1, every register holds zero and the word counter is zero.
- R2: With bit 0 of index 0x6C set and indices 0x69, 0x6A and 0x6B (z, x, y origin) all zero, an accepted write to index 0x6D raises `wr_valid` on the next cycle. The written value appears on `wr_data`.
- R3: The destination base is the value at index 0x62 in bits 63:32 and the value at index 0x63 in bits 31:0. A memory write goes to base + 4 × counter.
- R4: Each issued data word advances the counter by one, so successive words go to successive word addresses.
- R5: Any accepted write to index 0x6C sets the counter to zero, whatever value it carries.
- R6: A data write while bit 0 of index 0x6C is clear issues no memory write, does not advance the counter and sets `err_flag`.
- R7: A data write while any of indices 0x69, 0x6A or 0x6B is non-zero issues no memory write, does not advance the counter and sets `err_flag`.
- R8: A method write to an index of 0x7F or above changes no register and sets `err_flag`.
- R9: While `wr_valid` is high and `wr_ready` is low, `meth_ready` is low and `wr_addr` and `wr_data` hold their values.
- R10: Writes to indices other than 0x6C and 0x6D issue no memory write and leave the counter unchanged.
- R11: `err_flag` stays set until reset.
- R12: When the memory port accepts a word in the same cycle that a new data write is accepted, the new word follows on the next cycle. Nothing is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meth_valid | input | 1 | Method write present |
| meth_ready | output | 1 | Method write can be taken this cycle |
| meth_index | input | IDX_W | Register word index |
| meth_value | input | 32 | Register value |
| wr_valid | output | 1 | Memory write pending |
| wr_ready | input | 1 | Memory port accepts the pending write |
| wr_addr | output | 64 | Byte address of the memory write |
| wr_data | output | 32 | Data of the memory write |
| err_flag | output | 1 | Sticky error |

## Verification
Two events can fall in the same cycle:
- the memory port retiring the pending word;
- the engine accepting the next data method and loading a new word into the same output register.

The bench provokes this both with `wr_ready` held high under back-to-back data writes and with `wr_ready` toggled at random against a random method mix. Every word the port accepts is recorded and compared, in order, with a list that a bench model computes from the requirements. A dropped or repeated word therefore shows up as a count or address mismatch.

// File: rtl/inline_upload_engine.sv
module inline_upload_engine #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 127,
  parameter int OFF_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meth_valid,
  output logic             meth_ready,
  input  logic [IDX_W-1:0] meth_index,
  input  logic [31:0]      meth_value,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [63:0]      wr_addr,
  output logic [31:0]      wr_data,
  output logic             err_flag
);
  localparam int WIN_LO = 'h60;
  localparam int WIN_HI = 'h6D;
  localparam int WIN_N  = WIN_HI - WIN_LO + 1;
  localparam int SEL_W  = $clog2(WIN_N);
  localparam logic [IDX_W-1:0] I_LIMIT = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] I_LO    = IDX_W'(WIN_LO);
  localparam logic [IDX_W-1:0] I_HI    = IDX_W'(WIN_HI);
  localparam logic [IDX_W-1:0] I_EXEC  = IDX_W'('h6C);
  localparam logic [IDX_W-1:0] I_DATA  = IDX_W'('h6D);
  localparam int S_BHI = 'h62 - WIN_LO;
  localparam int S_BLO = 'h63 - WIN_LO;
  localparam int S_Z   = 'h69 - WIN_LO;
  localparam int S_X   = 'h6A - WIN_LO;
  localparam int S_Y   = 'h6B - WIN_LO;
  localparam int S_EX  = 'h6C - WIN_LO;

  logic [31:0]      win [WIN_N];
  logic [OFF_W-1:0] offset;
  logic             accept, in_win, bad_idx, upload_ok;
  logic [SEL_W-1:0] sel;
  logic [63:0]      base;

  assign meth_ready = !wr_valid || wr_ready;
  assign accept     = meth_valid && meth_ready;
  assign bad_idx    = meth_index >= I_LIMIT;
  assign in_win     = meth_index >= I_LO && meth_index <= I_HI;
  assign sel        = SEL_W'(meth_index - I_LO);
  assign base       = {win[S_BHI], win[S_BLO]};
  assign upload_ok  = win[S_EX][0] && win[S_Z] == '0 && win[S_X] == '0 && win[S_Y] == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      err_flag <= 1'b0;
      offset   <= '0;
      for (int i = 0; i < WIN_N; i++) win[i] <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (accept) begin
        if (bad_idx) begin
          err_flag <= 1'b1;
        end else begin
          if (in_win) win[sel] <= meth_value;
          if (meth_index == I_EXEC) offset <= '0;
          if (meth_index == I_DATA) begin
            if (upload_ok) begin
              wr_valid <= 1'b1;
              wr_addr  <= base + (64'(offset) << 2);
              wr_data  <= meth_value;
              offset   <= offset + 1'b1;
            end else begin
              err_flag <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/inline_upload_engine_chk.sv
module inline_upload_engine_chk #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 127
) (
  input logic             clk,
  input logic             rst,
  input logic             meth_valid,
  input logic             meth_ready,
  input logic [IDX_W-1:0] meth_index,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [63:0]      wr_addr,
  input logic [31:0]      wr_data,
  input logic             err_flag
);
  localparam logic [IDX_W-1:0] I_LIMIT = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] I_DATA  = IDX_W'('h6D);

  p_reset_r1: assert property (@(posedge clk) rst |=> !wr_valid && !err_flag);

  p_issue_r2: assert property (@(posedge clk) disable iff (rst)
    meth_valid && meth_ready && meth_index == I_DATA |=> wr_valid || err_flag);

  p_badidx_r8: assert property (@(posedge clk) disable iff (rst)
    meth_valid && meth_ready && meth_index >= I_LIMIT |=> err_flag);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind inline_upload_engine inline_upload_engine_chk #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst(rst), .meth_valid(meth_valid), .meth_ready(meth_ready),
  .meth_index(meth_index), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .err_flag(err_flag)
);

// File: tb/inline_upload_engine_tb_top.sv
module inline_upload_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8;

  logic clk = 0, rst = 1;
  logic meth_valid = 0, meth_ready;
  logic [IDX_W-1:0] meth_index = '0;
  logic [31:0] meth_value = '0;
  logic wr_valid, wr_ready = 1, err_flag;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  inline_upload_engine #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .meth_valid(meth_valid), .meth_ready(meth_ready),
    .meth_index(meth_index), .meth_value(meth_value), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit rnd_rdy = 0, force_rdy = 1;
  logic [63:0] got_a[$], exp_a[$];
  logic [31:0] got_d[$], exp_d[$];
  logic [31:0] m_hi, m_lo, m_x, m_y, m_z, m_off;
  bit m_lin, m_err;

  always @(negedge clk) wr_ready <= rnd_rdy ? 1'($urandom % 2) : force_rdy;
  always @(negedge clk) begin
    #1;
    if (!rst && wr_valid && wr_ready) begin
      got_a.push_back(wr_addr);
      got_d.push_back(wr_data);
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(logic [31:0] hi, logic [31:0] lo, logic [31:0] off);
    return {hi, lo} + (64'(off) << 2);
  endfunction

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    {m_hi, m_lo, m_x, m_y, m_z, m_off} = '0;
    m_lin = 0; m_err = 0;
    @(negedge clk); #2;
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
  endtask

  task automatic model(logic [IDX_W-1:0] idx, logic [31:0] v);
    if (idx >= 8'h7F) m_err = 1;
    else case (idx)
      8'h62: m_hi = v;
      8'h63: m_lo = v;
      8'h69: m_z = v;
      8'h6A: m_x = v;
      8'h6B: m_y = v;
      8'h6C: begin m_lin = v[0]; m_off = 0; end
      8'h6D: if (m_lin && m_x == 0 && m_y == 0 && m_z == 0) begin
               exp_a.push_back(exp_addr(m_hi, m_lo, m_off));
               exp_d.push_back(v);
               m_off++;
             end else m_err = 1;
      default: ;
    endcase
  endtask

  task automatic send(logic [IDX_W-1:0] idx, logic [31:0] v);
    @(negedge clk);
    meth_valid = 1; meth_index = idx; meth_value = v;
    #2;
    while (!meth_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    model(idx, v);
    #1 meth_valid = 0;
  endtask

  task automatic drain_compare(string req);
    int t = 0;
    while ((wr_valid || got_a.size() < exp_a.size()) && t < 200) begin @(negedge clk); t++; end
    @(negedge clk); #2;
    check(got_a.size() == exp_a.size(), req, 64'(got_a.size()), 64'(exp_a.size()));
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      check(got_a[i] == exp_a[i], req, got_a[i], exp_a[i]);
      check(got_d[i] == exp_d[i], req, 64'(got_d[i]), 64'(exp_d[i]));
    end
    check(err_flag == m_err, {req, " err"}, 64'(err_flag), 64'(m_err));
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    do_reset();
    // R1
    check(!wr_valid && !err_flag && meth_ready, "R1", {61'b0, wr_valid, err_flag, meth_ready}, 64'b1);
    // R2 R3 R4: three linear words
    send(8'h62, 32'h0000_0001); send(8'h63, 32'hFFFF_FFF8);
    send(8'h6C, 32'h1);
    send(8'h6D, 32'hA0A0_0001); send(8'h6D, 32'hA0A0_0002); send(8'h6D, 32'hA0A0_0003);
    drain_compare("R2 R3 R4");
    // R5: exec rewinds counter, value with bit0 set and extra bits
    send(8'h6C, 32'hFFFF_0001);
    send(8'h6D, 32'hB0B0_0001); send(8'h6D, 32'hB0B0_0002);
    drain_compare("R5");
    // R10: other registers have no side effect
    send(8'h60, 32'd16); send(8'h61, 32'd4); send(8'h64, 32'h100);
    send(8'h65, 32'h3); send(8'h66, 32'h55); send(8'h00, 32'h77); send(8'h7E, 32'h9);
    check(!wr_valid, "R10 no write", 64'(wr_valid), 64'd0);
    send(8'h6D, 32'hC0C0_0003);
    drain_compare("R10");
    // R9: stall holds word and blocks methods
    force_rdy = 0;
    @(negedge clk);
    send(8'h6D, 32'hD0D0_0004);
    @(negedge clk); #2;
    held = wr_addr;
    check(wr_valid && !meth_ready, "R9 ready", {62'b0, wr_valid, meth_ready}, 64'b10);
    repeat (3) @(negedge clk);
    #2;
    check(wr_valid && wr_addr == held && wr_data == 32'hD0D0_0004 && !meth_ready, "R9 hold", wr_addr, held);
    force_rdy = 1;
    drain_compare("R9");
    // R12: back-to-back words with port always ready
    for (int i = 0; i < 8; i++) send(8'h6D, 32'hE000_0000 + i);
    drain_compare("R12");
    // R6: linear flag clear
    send(8'h6C, 32'h0);
    send(8'h6D, 32'h1111_1111);
    drain_compare("R6");
    // R11: error survives later valid traffic
    send(8'h6C, 32'h1); send(8'h6D, 32'h2222_2222);
    repeat (5) @(negedge clk);
    drain_compare("R11");
    // R7: non-zero origin, each field in turn
    do_reset();
    send(8'h6C, 32'h1); send(8'h6A, 32'h4); send(8'h6D, 32'h3333_3333);
    drain_compare("R7 x");
    do_reset();
    send(8'h6C, 32'h1); send(8'h6B, 32'h1); send(8'h6D, 32'h3333_3334);
    drain_compare("R7 y");
    do_reset();
    send(8'h6C, 32'h1); send(8'h69, 32'h2); send(8'h6D, 32'h3333_3335);
    send(8'h69, 32'h0); send(8'h6D, 32'h3333_3336);
    drain_compare("R7 z");
    // R8: out-of-range index ignored, base unaffected
    do_reset();
    send(8'h62, 32'h10); send(8'h63, 32'h200); send(8'h6C, 32'h1);
    send(8'h7F, 32'hDEAD); send(8'hE2, 32'hBEEF); send(8'hFF, 32'h1);
    check(!wr_valid, "R8 no write", 64'(wr_valid), 64'd0);
    send(8'h6D, 32'h4444_4444);
    drain_compare("R8");
    // random mix: R2 R4 R5 R6 R7 R12
    do_reset();
    rnd_rdy = 1;
    send(8'h62, $urandom); send(8'h63, $urandom); send(8'h6C, 32'h1);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      if (r < 70) send(8'h6D, $urandom);
      else if (r < 76) send(8'h6C, (($urandom % 8) != 0) ? 32'h1 : 32'h0);
      else if (r < 80) send(IDX_W'(8'h69 + $urandom % 3), (($urandom % 4) == 0) ? 32'h1 : 32'h0);
      else if (r < 84) send(IDX_W'(8'h69 + $urandom % 3), 32'h0);
      else if (r < 99) send(IDX_W'(8'h60 + $urandom % 9), $urandom);
      else send(IDX_W'(8'h7F + $urandom % 129), $urandom);
    end
    drain_compare("R12 random");
    rnd_rdy = 0;
    finish_run();
  end
endmodule